// File: doc/BRIEF.md
# EEPROM Mode Control Register

This block is one 8-bit control register on a simple register bus that selects how the chip uses its serial configuration EEPROM. A two-bit mode field in the upper bits picks one of four modes. In normal operation the EEPROM pins stay idle. In the timed reload mode the block counts a fixed number of cycles, returns to normal by itself and pulses a reset to the neighbouring registers. In programming mode software toggles the EEPROM pins directly through the low bits, and network and bus-master activity is held off. In the write-enable mode a group of protected configuration registers will accept writes.

Software writes the mode field and, in programming mode, the pin bits. It reads the register back to see the mode and the live pin levels. The protected registers route their write requests through this block and take writes only when the grant is high. The reload itself, which is the serial read of the EEPROM, belongs to another block. This block supplies the timing window and the reset pulse that ends it.

Top module: `eeprom_mode_reg`

## Requirements
- R1: The register sits at address CTRL_ADDR. Bits 7:6 hold the mode: 00 normal, 01 reload, 10 programming, 11 config-write. An accepted write stores bits 7:6, and a read at CTRL_ADDR returns them. A read at any other address returns 0, and a write to any other address changes nothing.
- R2: A write of mode 01 starts a reload. The mode then reads 01 for exactly LOAD_CYCLES cycles after the write edge and reads 00 from the following cycle on, with no software action.
- R3: `softRstPulse` is high for exactly the one cycle in which the mode first reads 00 after a reload. It is low at every other time.
- R4: A register write made while the mode is 01 is ignored. The mode, the pins and the readback stay unchanged.
- R5: A write of mode 10 latches data bits 3, 2 and 1 onto `romCs`, `romSk` and `romDi` from the next cycle on. While in mode 10, read bits 3:1 return those pin levels and read bit 0 returns the live `romDo` input.
- R6: Write data bit 0 has no effect. While in mode 01, read bits 3:0 return {0,0,0,romDo}.
- R7: In modes 00 and 11, read bits 3:0 are 0. Every accepted write of a mode other than 10 drives `romCs`, `romSk` and `romDi` low.
- R8: Read bits 5:4 are always 0, and write data bits 5:4 have no effect.
- R9: `netDisable` is high exactly while the mode is 10.
- R10: `protWrGrant` follows `protWrReq` in the same cycle while the mode is 11. In every other mode it is 0, so protected writes made then are dropped.
- R11: After reset the mode is 00, all three pin outputs are low, and `softRstPulse`, `netDisable` and `protWrGrant` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regAddr | input | ADDR_W | Register bus address |
| regWe | input | 1 | Register bus write strobe |
| regWdata | input | 8 | Register bus write data |
| regRdata | output | 8 | Register bus read data (combinational) |
| romDo | input | 1 | EEPROM serial data out |
| romCs | output | 1 | EEPROM chip select |
| romSk | output | 1 | EEPROM serial clock |
| romDi | output | 1 | EEPROM serial data in |
| protWrReq | input | 1 | Write request from the protected registers |
| protWrGrant | output | 1 | Qualified write enable for the protected registers |
| netDisable | output | 1 | Holds off network and bus-master activity |
| softRstPulse | output | 1 | One-cycle reset to the other registers after a reload |

## Verification
The bench runs a reference model next to the design and compares every output on every clock. If the stored mode is wrong, the readback, `netDisable` and `protWrGrant` all show it in the same cycle, because they decode the mode combinationally. An error in the reload counter appears as a mode that returns too early or too late, together with a misplaced `softRstPulse`, in the cycle where the real and expected end points differ. A stale or misrouted pin latch shows on `romCs`, `romSk` and `romDi` one cycle after the write that should have set or cleared it.

// File: rtl/eeprom_mode_pkg.sv
package eeprom_mode_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL   = 2'b00,
    MODE_RELOAD   = 2'b01,
    MODE_PROGRAM  = 2'b10,
    MODE_CFGWRITE = 2'b11
  } eeMode_t;

  // Control-to-datapath strobes
  typedef struct packed {
    eeMode_t    mode;     // current stored mode
    logic       pinWr;    // an accepted write updates the pin latch
    logic [2:0] pinData;  // {cs, sk, di} to latch (zero unless programming)
  } ctrlStrobe_t;

endpackage

// File: rtl/eeprom_mode_ctrl.sv
module eeprom_mode_ctrl
  import eeprom_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20,
  parameter int LOAD_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  input  logic              protWrReq,
  output ctrlStrobe_t       strobe,
  output logic              softRstPulse,
  output logic              netDisable,
  output logic              protWrGrant
);

  localparam int CNT_W = (LOAD_CYCLES > 1) ? $clog2(LOAD_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LOAD_LAST = CNT_W'(LOAD_CYCLES - 1);

  eeMode_t          mode;
  eeMode_t          newMode;
  logic [CNT_W-1:0] loadCnt;
  logic             regHit;
  logic             wrAccept;
  logic             unusedWdata;

  assign unusedWdata = ^{regWdata[5:4], regWdata[0]};

  assign regHit   = regWe && (regAddr == CTRL_ADDR);
  assign wrAccept = regHit && (mode != MODE_RELOAD);
  assign newMode  = eeMode_t'(regWdata[7:6]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mode         <= MODE_NORMAL;
      loadCnt      <= '0;
      softRstPulse <= 1'b0;
    end else begin
      softRstPulse <= 1'b0;
      if (mode == MODE_RELOAD) begin
        if (loadCnt == '0) begin
          mode         <= MODE_NORMAL;
          softRstPulse <= 1'b1;
        end else begin
          loadCnt <= loadCnt - 1'b1;
        end
      end else if (wrAccept) begin
        mode <= newMode;
        if (newMode == MODE_RELOAD) begin
          loadCnt <= LOAD_LAST;
        end
      end
    end
  end

  always_comb begin
    strobe.mode    = mode;
    strobe.pinWr   = wrAccept;
    strobe.pinData = (newMode == MODE_PROGRAM) ? regWdata[3:1] : 3'b000;
  end

  assign netDisable  = (mode == MODE_PROGRAM);
  assign protWrGrant = protWrReq && (mode == MODE_CFGWRITE);

  AST_PULSE_ENDS_RELOAD: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |-> (mode == MODE_NORMAL) && ($past(mode) == MODE_RELOAD)); // R3
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    softRstPulse |=> !softRstPulse); // R3
  AST_RELOAD_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RELOAD) |=> (mode == MODE_RELOAD) || (mode == MODE_NORMAL)); // R4
  AST_RELOAD_EXIT_PULSES: assert property (@(posedge clk) disable iff (!rstN)
    (mode == MODE_RELOAD) ##1 (mode == MODE_NORMAL) |-> softRstPulse); // R2

endmodule

// File: rtl/eeprom_mode_pins.sv
module eeprom_mode_pins
  import eeprom_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              romDo,
  output logic              romCs,
  output logic              romSk,
  output logic              romDi,
  output logic [7:0]        regRdata
);

  logic [2:0] pinLatch;
  logic [3:0] lowBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinLatch <= 3'b000;
    end else if (strobe.pinWr) begin
      pinLatch <= strobe.pinData;
    end
  end

  assign romCs = pinLatch[2];
  assign romSk = pinLatch[1];
  assign romDi = pinLatch[0];

  always_comb begin
    unique case (strobe.mode)
      MODE_PROGRAM: lowBits = {pinLatch, romDo};
      MODE_RELOAD:  lowBits = {3'b000, romDo};
      default:      lowBits = 4'b0000;
    endcase
    regRdata = (regAddr == CTRL_ADDR) ? {strobe.mode, 2'b00, lowBits} : 8'h00;
  end

  AST_PINS_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.mode != MODE_PROGRAM) |-> !romCs && !romSk && !romDi); // R7
  AST_PINS_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobe.pinWr) |-> $stable(pinLatch)); // R4

endmodule

// File: rtl/eeprom_mode_reg.sv
module eeprom_mode_reg
  import eeprom_mode_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 'h20,
  parameter int LOAD_CYCLES = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWe,
  input  logic [7:0]        regWdata,
  output logic [7:0]        regRdata,
  input  logic              romDo,
  output logic              romCs,
  output logic              romSk,
  output logic              romDi,
  input  logic              protWrReq,
  output logic              protWrGrant,
  output logic              netDisable,
  output logic              softRstPulse
);

  ctrlStrobe_t strobe;

  eeprom_mode_ctrl #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .LOAD_CYCLES(LOAD_CYCLES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe),
    .regWdata(regWdata), .protWrReq(protWrReq), .strobe(strobe),
    .softRstPulse(softRstPulse), .netDisable(netDisable),
    .protWrGrant(protWrGrant)
  );

  eeprom_mode_pins #(
    .ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR)
  ) u_pins (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regAddr(regAddr),
    .romDo(romDo), .romCs(romCs), .romSk(romSk), .romDi(romDi),
    .regRdata(regRdata)
  );

endmodule

// File: tb/eeprom_mode_reg_bench.sv
module eeprom_mode_reg_bench;

  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] A = 8'h20;
  localparam int LOADN = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [ADDR_W-1:0] regAddr = '0;
  logic regWe = 1'b0;
  logic [7:0] regWdata = '0;
  logic romDo = 1'b0;
  logic protWrReq = 1'b0;
  logic [7:0] regRdata;
  logic romCs, romSk, romDi, protWrGrant, netDisable, softRstPulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // reference model state
  int mMode = 0;
  int mCnt = 0;
  int mPins = 0;
  int mPulse = 0;

  always #10 clk = ~clk;

  eeprom_mode_reg #(.ADDR_W(ADDR_W), .CTRL_ADDR(A), .LOAD_CYCLES(LOADN)) u_eeprom_mode_reg (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWe(regWe), .regWdata(regWdata),
    .regRdata(regRdata), .romDo(romDo), .romCs(romCs), .romSk(romSk), .romDi(romDi),
    .protWrReq(protWrReq), .protWrGrant(protWrGrant), .netDisable(netDisable),
    .softRstPulse(softRstPulse)
  );

  // Behavioural model, advanced on each rising edge
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mMode = 0; mCnt = 0; mPins = 0; mPulse = 0;
    end else begin
      mPulse = 0;
      if (mMode == 1) begin
        if (mCnt == 0) begin mMode = 0; mPulse = 1; end
        else mCnt = mCnt - 1;
      end else if (regWe && regAddr == A) begin
        mMode = regWdata[7:6];
        mPins = (mMode == 2) ? regWdata[3:1] : 0;
        if (mMode == 1) mCnt = LOADN - 1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual=%0h expected=%0h", tag, $time, act, exp);
    end
  endtask

  // Compare away from the clock edges
  always @(negedge clk) begin
    #5;
    if (!done) begin
      int low, expRd;
      string rdTag;
      if (mMode == 2) low = mPins * 2 + romDo;
      else if (mMode == 1) low = romDo;
      else low = 0;
      expRd = (regAddr == A) ? (mMode * 64 + low) : 0;
      if (!rstN) rdTag = "R11 R1";
      else if (mMode == 1) rdTag = "R2 R4 R6 R8";
      else if (mMode == 2) rdTag = "R1 R5 R6 R8";
      else rdTag = "R1 R7 R8";
      check(rdTag, regRdata, expRd);
      check(rstN ? "R5 R7 pins" : "R11 pins", {romCs, romSk, romDi}, mPins);
      check(rstN ? "R3 pulse" : "R11 pulse", softRstPulse, mPulse);
      check("R9 netDisable", netDisable, mMode == 2);
      check("R10 grant", protWrGrant, protWrReq && mMode == 3);
    end
  end

  task automatic drive(bit we, logic [7:0] addr, logic [7:0] data, bit dOut, bit req);
    @(negedge clk);
    regWe = we; regAddr = addr; regWdata = data; romDo = dOut; protWrReq = req;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) drive(1'b0, A, 8'h00, romDo, protWrReq);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R10: protected request outside config-write is dropped
    drive(1'b0, A, 8'h00, 1'b0, 1'b1);
    // R5: programming with pin patterns, romDo live
    drive(1'b1, A, 8'b10_00_1110, 1'b1, 1'b0);
    drive(1'b0, A, 8'h00, 1'b0, 1'b1);
    drive(1'b1, A, 8'b10_11_0101, 1'b1, 1'b0);   // R6 R8 bit0 and reserved written
    drive(1'b0, A, 8'h00, 1'b1, 1'b0);
    drive(1'b1, A, 8'b10_00_1001, 1'b0, 1'b0);
    // R1: write to another address is ignored
    drive(1'b1, 8'h21, 8'b11_00_0000, 1'b0, 1'b0);
    drive(1'b0, 8'h21, 8'h00, 1'b0, 1'b0);
    // R7: config-write clears pins; R10 grant follows request
    drive(1'b1, A, 8'b11_00_1110, 1'b0, 1'b0);
    drive(1'b0, A, 8'h00, 1'b0, 1'b1);
    drive(1'b0, A, 8'h00, 1'b0, 1'b0);
    drive(1'b0, A, 8'h00, 1'b0, 1'b1);
    // R2 R3: reload with writes during it (R4)
    drive(1'b1, A, 8'b10_00_1110, 1'b0, 1'b0);
    drive(1'b1, A, 8'b01_00_1110, 1'b1, 1'b0);
    drive(1'b1, A, 8'b10_00_1110, 1'b0, 1'b0);
    drive(1'b1, A, 8'b11_00_0000, 1'b1, 1'b1);
    idle(LOADN + 3);
    // back-to-back reloads
    drive(1'b1, A, 8'b01_00_0000, 1'b0, 1'b0);
    idle(LOADN);
    drive(1'b1, A, 8'b01_00_0000, 1'b0, 1'b0);
    idle(LOADN + 2);
    // programming then normal clears pins
    drive(1'b1, A, 8'b10_00_1110, 1'b1, 1'b0);
    drive(1'b1, A, 8'b00_00_1110, 1'b1, 1'b0);
    idle(2);
    // random phase
    for (int i = 0; i < 600; i++) begin
      logic [7:0] ad;
      ad = ($urandom % 4 == 0) ? 8'h33 : A;
      drive(($urandom % 2) == 1, ad, 8'($urandom), ($urandom % 2) == 1, ($urandom % 2) == 1);
    end
    // R11: reset in the middle of programming
    drive(1'b1, A, 8'b10_00_1110, 1'b0, 1'b0);
    drive(1'b0, A, 8'h00, 1'b0, 1'b0);
    rstN = 1'b0;
    idle(2);
    rstN = 1'b1;
    idle(3);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule